// File: doc/BRIEF.md
# Strobe-Paced Three-Track Buffer Unloader

This block is the read-out half of a three-track card buffer. Once the capture side reports that a swipe has been stored, the host pulls the stored bits out one at a time. It toggles a single strobe line, and the block answers on a single data line that idles high. The host strobe is asynchronous to the block clock. It passes through a two-stage synchronizer, and only its rising edges advance the read position. After each counted edge the block puts the next value on the data line, and the host samples it before its next rising edge.

A read-out always takes the same number of strobes. Two handshake strobes come first, then sixteen lead-in strobes, and then twenty-four segments of one full track each. The segments visit the tracks in the pattern A B C C B A, four times over. Each group of three segments is one pass. Even passes read a track from bit 0 upward, and odd passes read it from the top bit downward. This lets the host recover a card swiped in either direction without storing the whole card. Tracks that hold nothing are still clocked out in full.

The final strobe does three things: it clears the external buffer, pulls the data line low, and starts a hold time. At the end of the hold time the block re-arms, unless a card is still passing the head, in which case it waits for the card to leave. The data stream has no back-pressure and no valid/ready pair. The host sets the pace entirely through the strobe, and the block never stalls it.

Top module: `strobe_track_unloader`

## Requirements
- R1: After reset the data line is high, capture enable is high, and the clear pulse is low.
- R2: While armed, strobe edges have no effect on the data line. A high buffer-ready input moves the block to the loaded state, and the data line goes low on the next clock.
- R3: After loading, the data line is high following each of strobes 1 to 17. Strobes 1 and 2 form the handshake and strobes 3 to 18 the lead-in.
- R4: Data bit k of the stream (k = 0 to 14591) is shown after strobe 18+k, with segment s = k / 608 and bit b = k mod 608.
- R5: Segment s reads track s mod 3 when the pass p = s / 3 is even, and track 2 - (s mod 3) when p is odd. Tracks are A=0, B=1, C=2, so the order is A B C C B A repeated four times.
- R6: In even passes the buffer address is b; in odd passes it is 607 - b.
- R7: Every segment takes exactly 608 strobes whatever the track holds, so the clear always falls on strobe 14610.
- R8: On strobe 14610 the data line goes low and the buffer clear output pulses high for exactly one clock.
- R9: After a clear, the data line stays low for CLR_HOLD clocks and then returns high, with capture enable high, when no card is present.
- R10: If a card is present when the hold time ends, the data line stays low until the card is gone, and goes high on the clock after.
- R11: Capture enable is low from loading until re-arm, and buffer-ready is ignored during that time.
- R12: A raw strobe rise changes the data line on the third clock edge after it. A strobe held high for many clocks counts once.
- R13: The debug outputs give the segment and bit index of the bit currently shown during the data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe_in | input | 1 | Raw host strobe, asynchronous |
| data_out | output | 1 | Serial data line, idles high |
| buf_ready_in | input | 1 | Capture side reports a stored swipe |
| card_present_in | input | 1 | A card is passing the head |
| capture_en_out | output | 1 | Capture side may accept a new swipe |
| buf_clear_out | output | 1 | One-clock pulse that sets all buffer bits high |
| rd_track_out | output | TRK_W | Track index of the buffer read port |
| rd_addr_out | output | BIT_W | Bit address of the buffer read port |
| rd_data_in | input | 1 | Buffer bit at the addressed location, combinational |
| dbg_seg_out | output | SEG_W | Segment index of the bit currently shown |
| dbg_bit_out | output | BIT_W | Bit index within the segment of the bit currently shown |

## Verification
The embedded assertions check rules that hold on every clock. They confirm that the clear pulse lasts one clock and that the data line is low beside it. They also confirm that the read pointer steps by exactly one position per counted edge, that the shown bit never changes without an edge, and that the block stays in the waiting state while a card is present. The cycle-accurate reference model in the bench is what shows the whole read-out. It covers the A B C C B A order, the direction reversal on odd passes, the placement of the clear on strobe 14610, the three-edge synchronizer latency, and the second read-out returning all-high data from the cleared buffer.

// File: rtl/tu_pkg.sv
package tu_pkg;
  typedef enum logic [1:0] {
    ARM_IDLE   = 2'd0,
    ARM_LOADED = 2'd1,
    ARM_HOLD   = 2'd2,
    ARM_WAIT   = 2'd3
  } arm_state_t;

  typedef enum logic [1:0] {
    PH_SHAKE = 2'd0,
    PH_LEAD  = 2'd1,
    PH_BITS  = 2'd2
  } phase_t;
endpackage

// File: rtl/tu_strobe_sync.sv
module tu_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_raw,
  output logic rise_o
);
  logic [STAGES:0] chain_q;

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= strobe_raw;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/tu_seg_map.sv
module tu_seg_map #(
  parameter int NUM_TRACKS = 3,
  parameter int TRACK_BITS = 608,
  parameter int SEG_W      = 5,
  parameter int BIT_W      = 10,
  parameter int TRK_W      = 2
) (
  input  logic [SEG_W-1:0] seg_i,
  input  logic [BIT_W-1:0] bit_i,
  output logic [TRK_W-1:0] track_o,
  output logic [BIT_W-1:0] addr_o
);
  logic [SEG_W-1:0] pass_w;
  logic [SEG_W-1:0] pos_w;
  logic             fwd_w;

  always_comb begin
    pass_w = seg_i / SEG_W'(NUM_TRACKS);
    pos_w  = seg_i % SEG_W'(NUM_TRACKS);
    fwd_w  = ~pass_w[0];
    if (fwd_w) begin
      track_o = TRK_W'(pos_w);
      addr_o  = bit_i;
    end else begin
      track_o = TRK_W'(SEG_W'(NUM_TRACKS - 1) - pos_w);
      addr_o  = BIT_W'(TRACK_BITS - 1) - bit_i;
    end
  end
endmodule

// File: rtl/tu_unload_seq.sv
module tu_unload_seq
  import tu_pkg::*;
#(
  parameter int NUM_TRACKS   = 3,
  parameter int TRACK_BITS   = 608,
  parameter int PATTERN_REPS = 4,
  parameter int SHAKE_LEN    = 2,
  parameter int LEAD_LEN     = 16,
  localparam int SEGS  = 2 * NUM_TRACKS * PATTERN_REPS,
  localparam int SEG_W = $clog2(SEGS),
  localparam int BIT_W = $clog2(TRACK_BITS),
  localparam int TRK_W = (NUM_TRACKS > 1) ? $clog2(NUM_TRACKS) : 1,
  localparam int CNT_MAX = (SHAKE_LEN > LEAD_LEN) ? SHAKE_LEN : LEAD_LEN,
  localparam int CNT_W = $clog2(CNT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             run_i,
  input  logic             rise_i,
  input  logic             rd_data_i,
  output logic [TRK_W-1:0] rd_track_o,
  output logic [BIT_W-1:0] rd_addr_o,
  output logic             data_o,
  output logic             last_o,
  output logic [SEG_W-1:0] seg_o,
  output logic [BIT_W-1:0] bit_o
);
  phase_t           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SEG_W-1:0] seg_q, nseg_w;
  logic [BIT_W-1:0] bit_q, nbit_w;
  logic             data_q;
  logic             at_end_w;
  logic             step_w;

  assign at_end_w = (phase_q == PH_BITS) && (seg_q == SEG_W'(SEGS - 1)) &&
                    (bit_q == BIT_W'(TRACK_BITS - 1));
  assign step_w   = run_i && rise_i && !start_i;
  assign last_o   = step_w && at_end_w;

  always_comb begin
    nseg_w = '0;
    nbit_w = '0;
    if (phase_q == PH_BITS) begin
      if (bit_q == BIT_W'(TRACK_BITS - 1)) begin
        nseg_w = seg_q + SEG_W'(1);
        nbit_w = '0;
      end else begin
        nseg_w = seg_q;
        nbit_w = bit_q + BIT_W'(1);
      end
    end
  end

  tu_seg_map #(
    .NUM_TRACKS (NUM_TRACKS),
    .TRACK_BITS (TRACK_BITS),
    .SEG_W      (SEG_W),
    .BIT_W      (BIT_W),
    .TRK_W      (TRK_W)
  ) map_i (
    .seg_i   (nseg_w),
    .bit_i   (nbit_w),
    .track_o (rd_track_o),
    .addr_o  (rd_addr_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_SHAKE;
      cnt_q   <= '0;
      seg_q   <= '0;
      bit_q   <= '0;
      data_q  <= 1'b1;
    end else if (start_i) begin
      phase_q <= PH_SHAKE;
      cnt_q   <= '0;
      seg_q   <= '0;
      bit_q   <= '0;
      data_q  <= 1'b0;
    end else if (step_w) begin
      case (phase_q)
        PH_SHAKE: begin
          data_q <= 1'b1;
          if (cnt_q == CNT_W'(SHAKE_LEN - 1)) begin
            phase_q <= PH_LEAD;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        PH_LEAD: begin
          if (cnt_q == CNT_W'(LEAD_LEN - 1)) begin
            phase_q <= PH_BITS;
            cnt_q   <= '0;
            data_q  <= rd_data_i;
          end else begin
            cnt_q  <= cnt_q + CNT_W'(1);
            data_q <= 1'b1;
          end
        end
        PH_BITS: begin
          if (!at_end_w) begin
            seg_q  <= nseg_w;
            bit_q  <= nbit_w;
            data_q <= rd_data_i;
          end
        end
        default: phase_q <= PH_SHAKE;
      endcase
    end
  end

  assign data_o = data_q;
  assign seg_o  = seg_q;
  assign bit_o  = bit_q;

  AST_BIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_q < BIT_W'(TRACK_BITS)); // R13
  AST_SEG_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    seg_q < SEG_W'(SEGS)); // R13
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_w && phase_q == PH_BITS && !at_end_w) |=>
      ((bit_q == $past(bit_q) + BIT_W'(1)) ||
       (bit_q == '0 && seg_q == $past(seg_q) + SEG_W'(1)))); // R4
  AST_NO_EDGE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_i && !start_i) |=> $stable(data_q)); // R12
endmodule

// File: rtl/tu_rearm_ctrl.sv
module tu_rearm_ctrl
  import tu_pkg::*;
#(
  parameter int CLR_HOLD = 1000,
  localparam int TMR_W = $clog2(CLR_HOLD + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ready_i,
  input  logic       card_i,
  input  logic       last_i,
  output arm_state_t state_o,
  output logic       start_o,
  output logic       clear_o
);
  arm_state_t       state_q;
  logic [TMR_W-1:0] tmr_q;
  logic             clear_q;

  assign start_o = (state_q == ARM_IDLE) && ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARM_IDLE;
      tmr_q   <= '0;
      clear_q <= 1'b0;
    end else begin
      clear_q <= 1'b0;
      case (state_q)
        ARM_IDLE: begin
          if (ready_i) state_q <= ARM_LOADED;
        end
        ARM_LOADED: begin
          if (last_i) begin
            state_q <= ARM_HOLD;
            tmr_q   <= '0;
            clear_q <= 1'b1;
          end
        end
        ARM_HOLD: begin
          if (tmr_q == TMR_W'(CLR_HOLD - 1)) begin
            state_q <= card_i ? ARM_WAIT : ARM_IDLE;
          end else begin
            tmr_q <= tmr_q + TMR_W'(1);
          end
        end
        ARM_WAIT: begin
          if (!card_i) state_q <= ARM_IDLE;
        end
        default: state_q <= ARM_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign clear_o = clear_q;

  AST_CLEAR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    clear_q |=> !clear_q); // R8
  AST_WAIT_FOR_CARD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ARM_WAIT && card_i) |=> (state_q == ARM_WAIT)); // R10
  AST_HOLD_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ARM_HOLD && tmr_q < TMR_W'(CLR_HOLD - 1)) |=> (state_q == ARM_HOLD)); // R9
endmodule

// File: rtl/strobe_track_unloader.sv
module strobe_track_unloader
  import tu_pkg::*;
#(
  parameter int NUM_TRACKS   = 3,
  parameter int TRACK_BITS   = 608,
  parameter int PATTERN_REPS = 4,
  parameter int SHAKE_LEN    = 2,
  parameter int LEAD_LEN     = 16,
  parameter int CLR_HOLD     = 1000,
  parameter int SYNC_STAGES  = 2,
  localparam int SEGS  = 2 * NUM_TRACKS * PATTERN_REPS,
  localparam int SEG_W = $clog2(SEGS),
  localparam int BIT_W = $clog2(TRACK_BITS),
  localparam int TRK_W = (NUM_TRACKS > 1) ? $clog2(NUM_TRACKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_in,
  output logic             data_out,
  input  logic             buf_ready_in,
  input  logic             card_present_in,
  output logic             capture_en_out,
  output logic             buf_clear_out,
  output logic [TRK_W-1:0] rd_track_out,
  output logic [BIT_W-1:0] rd_addr_out,
  input  logic             rd_data_in,
  output logic [SEG_W-1:0] dbg_seg_out,
  output logic [BIT_W-1:0] dbg_bit_out
);
  logic       rise_w;
  logic       start_w;
  logic       last_w;
  logic       seq_data_w;
  arm_state_t state_w;

  tu_strobe_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe_raw (strobe_in),
    .rise_o     (rise_w)
  );

  tu_unload_seq #(
    .NUM_TRACKS   (NUM_TRACKS),
    .TRACK_BITS   (TRACK_BITS),
    .PATTERN_REPS (PATTERN_REPS),
    .SHAKE_LEN    (SHAKE_LEN),
    .LEAD_LEN     (LEAD_LEN)
  ) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_w),
    .run_i      (state_w == ARM_LOADED),
    .rise_i     (rise_w),
    .rd_data_i  (rd_data_in),
    .rd_track_o (rd_track_out),
    .rd_addr_o  (rd_addr_out),
    .data_o     (seq_data_w),
    .last_o     (last_w),
    .seg_o      (dbg_seg_out),
    .bit_o      (dbg_bit_out)
  );

  tu_rearm_ctrl #(.CLR_HOLD(CLR_HOLD)) rearm_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ready_i (buf_ready_in),
    .card_i  (card_present_in),
    .last_i  (last_w),
    .state_o (state_w),
    .start_o (start_w),
    .clear_o (buf_clear_out)
  );

  always_comb begin
    case (state_w)
      ARM_IDLE:   data_out = 1'b1;
      ARM_LOADED: data_out = seq_data_w;
      default:    data_out = 1'b0;
    endcase
  end

  assign capture_en_out = (state_w == ARM_IDLE);

  AST_LAST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    last_w |=> (buf_clear_out && !data_out)); // R8
  AST_TRACK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_track_out < TRK_W'(NUM_TRACKS)); // R5
  AST_LOCKED_WHILE_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture_en_out && !buf_clear_out && $past(!capture_en_out) && buf_ready_in && !rise_w)
      |=> !capture_en_out || $past(state_w != ARM_LOADED)); // R11
endmodule

// File: tb/strobe_track_unloader_tb.sv
module strobe_track_unloader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 24;
  localparam int NBITS = 608;
  localparam int TOTAL = 14610;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe_in = 1'b0;
  logic buf_ready_in = 1'b0;
  logic card_present_in = 1'b0;
  logic data_out, capture_en_out, buf_clear_out, rd_data_in;
  logic [1:0] rd_track_out;
  logic [9:0] rd_addr_out;
  logic [4:0] dbg_seg_out;
  logic [9:0] dbg_bit_out;

  logic [NBITS-1:0] mem [3];

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // reference model state
  int m_mode = 0;   // 0 armed, 1 loaded, 2 hold, 3 wait
  int m_n = 0;
  int m_hc = 0;
  bit m_clr = 0;
  bit m_data = 1;
  bit m_s1 = 0, m_s2 = 0, m_s3 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_track_unloader #(.CLR_HOLD(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .strobe_in(strobe_in), .data_out(data_out),
    .buf_ready_in(buf_ready_in), .card_present_in(card_present_in),
    .capture_en_out(capture_en_out), .buf_clear_out(buf_clear_out),
    .rd_track_out(rd_track_out), .rd_addr_out(rd_addr_out), .rd_data_in(rd_data_in),
    .dbg_seg_out(dbg_seg_out), .dbg_bit_out(dbg_bit_out)
  );

  assign rd_data_in = (rd_track_out < 2'd3 && rd_addr_out < 10'(NBITS)) ?
                      mem[rd_track_out][rd_addr_out] : 1'b1;

  function automatic bit exp_stream_bit(int n);
    int k, s, b, p, pos, trk, adr;
    k = n - 18; s = k / NBITS; b = k % NBITS;
    p = s / 3; pos = s % 3;
    trk = (p % 2 == 0) ? pos : 2 - pos;
    adr = (p % 2 == 0) ? b : NBITS - 1 - b;
    return mem[trk][adr];
  endfunction

  task automatic check(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic check_int(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // environment: the buffer responds to the clear pulse
  always @(posedge clk) begin
    if (buf_clear_out) for (int t = 0; t < 3; t++) mem[t] = '1;
  end

  // behavioural reference, updated on every rising edge
  always @(posedge clk) begin
    bit rise;
    if (!rst_n) begin
      m_mode = 0; m_n = 0; m_hc = 0; m_clr = 0; m_data = 1;
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      rise = m_s2 && !m_s3;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = strobe_in;
      m_clr = 0;
      case (m_mode)
        0: if (buf_ready_in) begin m_mode = 1; m_n = 0; m_data = 0; end
        1: if (rise) begin
             m_n++;
             if (m_n == TOTAL) begin m_mode = 2; m_hc = 0; m_clr = 1; end
             else if (m_n < 18) m_data = 1;
             else m_data = exp_stream_bit(m_n);
           end
        2: begin
             m_hc++;
             if (m_hc == HOLD) m_mode = card_present_in ? 3 : 0;
           end
        default: if (!card_present_in) m_mode = 0;
      endcase
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    bit ed;
    if (rst_n && !done) begin
      ed = (m_mode == 0) ? 1'b1 : (m_mode == 1) ? m_data : 1'b0;
      if (m_mode == 1) check((m_n < 18) ? "R3" : "R5", data_out, ed, "data line in read-out");
      else if (m_mode == 2) check("R9", data_out, ed, "data line in hold");
      else if (m_mode == 3) check("R10", data_out, ed, "data line waiting for card");
      else check("R2", data_out, ed, "data line while armed");
      check("R8", buf_clear_out, m_clr, "clear pulse");
      check("R11", capture_en_out, m_mode == 0, "capture enable");
      if (m_mode == 1 && m_n >= 18) begin
        check_int("R13", int'(dbg_seg_out), (m_n - 18) / NBITS, "segment index");
        check_int("R13", int'(dbg_bit_out), (m_n - 18) % NBITS, "bit index");
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected below 190000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wait_neg(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic one_strobe();
    strobe_in = 1'b1; wait_neg(2);
    strobe_in = 1'b0; wait_neg(2);
  endtask

  task automatic read_out(bit card_in_hold);
    // strobe 1 with latency check (R12)
    strobe_in = 1'b1;
    wait_neg(2);
    check("R12", data_out, 1'b0, "no change two edges after raw rise");
    wait_neg(1);
    check("R12", data_out, 1'b1, "change on third edge after raw rise");
    wait_neg(16); // held high long: counts once
    strobe_in = 1'b0; wait_neg(2);
    for (int n = 2; n < TOTAL; n++) begin
      if (n == 10) begin
        buf_ready_in = 1'b1; card_present_in = 1'b1; // R11: ignored while loaded
      end
      if (n == 12) begin buf_ready_in = 1'b0; card_present_in = 1'b0; end
      one_strobe();
      if (n == 17) check("R3", data_out, 1'b1, "last lead-in shows high");
      if (n == 18) begin
        check("R4", data_out, mem[0][0], "first data bit track A bit 0");
        check_int("R12", int'(dbg_bit_out), 0, "long strobe counted once");
      end
      if (n == 18 + 2 * NBITS) check("R5", data_out, mem[2][0], "segment 2 reads track C");
      if (n == 18 + 4 * NBITS) check("R6", data_out, mem[1][NBITS-1], "odd pass reads track B from top");
      if (n == 18 + 5 * NBITS + 3) check("R6", data_out, mem[0][NBITS-4], "odd pass track A reversed");
      if (n == TOTAL - 1) begin
        check_int("R7", int'(dbg_seg_out), 23, "last segment reached");
        check_int("R7", int'(dbg_bit_out), NBITS - 1, "last bit reached");
        check("R11", capture_en_out, 1'b0, "capture stays off before clear");
      end
    end
    if (card_in_hold) card_present_in = 1'b1;
    strobe_in = 1'b1;
    wait_neg(3);
    check("R8", data_out, 1'b0, "data low on final strobe");
    check("R8", buf_clear_out, 1'b1, "clear pulse on final strobe");
    wait_neg(1);
    check("R8", buf_clear_out, 1'b0, "clear pulse one clock");
    strobe_in = 1'b0;
    wait_neg(HOLD - 2);
    check("R9", data_out, 1'b0, "still low at end of hold");
    wait_neg(1);
    if (!card_in_hold) begin
      check("R9", data_out, 1'b1, "re-armed after hold");
      check("R9", capture_en_out, 1'b1, "capture enabled after hold");
    end else begin
      wait_neg(40);
      check("R10", data_out, 1'b0, "held low while card present");
      card_present_in = 1'b0;
      wait_neg(1);
      check("R10", data_out, 1'b1, "released once card gone");
    end
  endtask

  initial begin
    for (int b = 0; b < NBITS; b++) begin
      mem[0][b] = (b % 5 == 1);
      mem[1][b] = (b % 3 == 0);
      mem[2][b] = 1'b1; // empty track
    end
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(1);
    check("R1", data_out, 1'b1, "reset data line");
    check("R1", capture_en_out, 1'b1, "reset capture enable");
    check("R1", buf_clear_out, 1'b0, "reset clear pulse");
    one_strobe(); one_strobe();
    check("R2", data_out, 1'b1, "strobes ignored while armed");
    wait_neg(4);
    buf_ready_in = 1'b1;
    wait_neg(1);
    buf_ready_in = 1'b0;
    check("R2", data_out, 1'b0, "ready pulls data low");
    check("R11", capture_en_out, 1'b0, "capture off when loaded");
    wait_neg(3);
    read_out(1'b1);
    wait_neg(5);
    buf_ready_in = 1'b1;
    wait_neg(1);
    buf_ready_in = 1'b0;
    wait_neg(2);
    read_out(1'b0);
    check("R8", mem[0][1], 1'b1, "buffer cleared to high");
    wait_neg(4);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule